// File: doc/BRIEF.md
# Pin Function Select and Output Latch Controller

This block is the register core of a general-purpose pin unit with 54 pins. Each pin has a 3-bit function code that chooses between plain input, plain output, or one of six alternate functions. A separate output latch per pin holds the value driven when the pin is a plain output. Software changes that latch only through a set register and a clear register, each with one word per bank. A 1 in either register acts on its own pin and a 0 does nothing, so software never needs a read-modify-write. A level register returns the synchronized pad inputs. Pins are grouped in banks of 32, so the second bank holds pins 32 to 53.

The bus side is a plain 32-bit write port and a combinational read port, addressed by word-aligned byte offsets. Address bits [1:0] are ignored. The pad side drives, for every pin, the output value, an output enable, and the alternate-function code. That code goes to an external mux, which this block does not contain.

Top module: `pinmux_gpio_core`

## Requirements
- R1: After reset every function code is 0 (input), every output latch is 0, pad_oe is all zero and pad_alt_sel is all zero.
- R2: Function words are at offsets 0x00, 0x04, … 0x14. Pin p uses word p/10 at bits [(p mod 10)*3+2 : (p mod 10)*3]. A write stores these fields and a read returns them. Bits 31:30 of every function word read 0.
- R3: pad_oe of pin p is 1 exactly when the function code of pin p is 1.
- R4: Codes 2 to 7 select the alternate functions (alt5=2, alt4=3, alt0=4, alt1=5, alt2=6, alt3=7) and appear unchanged on pad_alt_sel[p*3+2:p*3]. Codes 0 and 1 give 0 on pad_alt_sel.
- R5: A write to the set register (0x1C for pins 0–31, 0x20 for pins 32–53) sets the latch of pin bank*32+k for each data bit k that is 1. Bits that are 0 leave their latches unchanged. The change shows on pad_out in the cycle after the write edge.
- R6: A write to the clear register (0x28 for bank 0, 0x2C for bank 1) clears the latch of each pin whose data bit is 1. Bits that are 0 leave their latches unchanged.
- R7: The set and clear registers always read 0.
- R8: The level register (0x34 for bank 0, 0x38 for bank 1) shows pad_in through a two-flop synchronizer. A change in pad_in appears after the second rising edge, and not after the first.
- R9: These locations read 0 and ignore writes: pins above 53 (bank-1 bits 31:22, function word 0x14 bits 31:12) and unmapped offsets (0x18, 0x24, 0x30, 0x3C and above).
- R10: pad_out always follows the output latch, whatever the function code. A latch written while its pin is an input keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 54 | Pad input levels, asynchronous |
| pad_out | output | 54 | Output latch per pin |
| pad_oe | output | 54 | Output enable per pin |
| pad_alt_sel | output | 162 | Alternate-function code, 3 bits per pin |

## Verification
The hardest case to reach is a latch that must stay unchanged while its word is written. That means a set or clear write with mostly zero bits, or a write to a bank-1 bit above pin 53. Unrelated writes also hit the same words, so any stray change has to stay visible until it is checked. The stimulus sends sparse random masks to the set and clear registers and compares the full 54-bit pad_out against a bench model after every write. The function-word sequence also places every code, including the two out-of-order alternate codes, on adjacent pins in one word, so that pad_oe and pad_alt_sel are checked field by field.

// File: rtl/gpio_core_pkg.sv
package gpio_core_pkg;
    localparam int FSEL_W         = 3;
    localparam int PINS_PER_FWORD = 10;
    localparam int WORD_W         = 32;
    // word indices (byte offset / 4) of the per-bank registers
    localparam int SET_WORD = 7;
    localparam int CLR_WORD = 10;
    localparam int LEV_WORD = 13;

    typedef enum logic [2:0] {
        FN_IN   = 3'd0,
        FN_OUT  = 3'd1,
        FN_ALT5 = 3'd2,
        FN_ALT4 = 3'd3,
        FN_ALT0 = 3'd4,
        FN_ALT1 = 3'd5,
        FN_ALT2 = 3'd6,
        FN_ALT3 = 3'd7
    } fn_code_e;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_FSEL,
        RG_SET,
        RG_CLR,
        RG_LEV
    } reg_kind_e;
endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
    import gpio_core_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int FSEL_WORDS = 6,
    parameter int NUM_BANKS  = 2,
    parameter int IDX_W      = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [IDX_W-1:0]  idx
);
    logic [ADDR_W-3:0] word;
    logic [1:0]        unused_lsb;
    int                w;

    assign word       = addr[ADDR_W-1:2];
    assign unused_lsb = addr[1:0];

    always_comb begin
        w    = int'(word);
        kind = RG_NONE;
        idx  = '0;
        if (w < FSEL_WORDS) begin
            kind = RG_FSEL;
            idx  = IDX_W'(w);
        end else if (w >= SET_WORD && w < SET_WORD + NUM_BANKS) begin
            kind = RG_SET;
            idx  = IDX_W'(w - SET_WORD);
        end else if (w >= CLR_WORD && w < CLR_WORD + NUM_BANKS) begin
            kind = RG_CLR;
            idx  = IDX_W'(w - CLR_WORD);
        end else if (w >= LEV_WORD && w < LEV_WORD + NUM_BANKS) begin
            kind = RG_LEV;
            idx  = IDX_W'(w - LEV_WORD);
        end
    end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 54
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/gpio_pad_drv.sv
module gpio_pad_drv
    import gpio_core_pkg::*;
#(
    parameter int NUM_PINS = 54
) (
    input  logic [NUM_PINS-1:0][FSEL_W-1:0] fsel,
    output logic [NUM_PINS-1:0]             oe,
    output logic [NUM_PINS*FSEL_W-1:0]      alt_sel
);
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        logic is_gpio;
        assign is_gpio = (fsel[p] == FN_IN) || (fsel[p] == FN_OUT);
        assign oe[p]   = (fsel[p] == FN_OUT);
        assign alt_sel[p*FSEL_W +: FSEL_W] = is_gpio ? '0 : fsel[p];
    end
endmodule

// File: rtl/pinmux_gpio_core.sv
module pinmux_gpio_core
    import gpio_core_pkg::*;
#(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_we,
    input  logic [ADDR_W-1:0]          bus_addr,
    input  logic [WORD_W-1:0]          bus_wdata,
    output logic [WORD_W-1:0]          bus_rdata,
    input  logic [NUM_PINS-1:0]        pad_in,
    output logic [NUM_PINS-1:0]        pad_out,
    output logic [NUM_PINS-1:0]        pad_oe,
    output logic [NUM_PINS*FSEL_W-1:0] pad_alt_sel
);
    localparam int FSEL_WORDS = (NUM_PINS + PINS_PER_FWORD - 1) / PINS_PER_FWORD;
    localparam int NUM_BANKS  = (NUM_PINS + WORD_W - 1) / WORD_W;
    localparam int IDX_W      = $clog2(FSEL_WORDS + 1);

    typedef struct packed {
        logic [NUM_PINS-1:0][FSEL_W-1:0] fsel;
        logic [NUM_PINS-1:0]             dout;
    } state_t;

    state_t             state_d, state_q;
    reg_kind_e          kind;
    logic [IDX_W-1:0]   idx;
    logic [NUM_PINS-1:0] lev;

    gpio_addr_dec #(
        .ADDR_W    (ADDR_W),
        .FSEL_WORDS(FSEL_WORDS),
        .NUM_BANKS (NUM_BANKS),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind),
        .idx (idx)
    );

    gpio_sync #(.W(NUM_PINS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pad_in),
        .q    (lev)
    );

    gpio_pad_drv #(.NUM_PINS(NUM_PINS)) u_drv (
        .fsel   (state_q.fsel),
        .oe     (pad_oe),
        .alt_sel(pad_alt_sel)
    );

    // next-state: function fields and output latch
    always_comb begin
        state_d = state_q;
        if (bus_we) begin
            for (int p = 0; p < NUM_PINS; p++) begin
                if (kind == RG_FSEL && int'(idx) == p / PINS_PER_FWORD)
                    state_d.fsel[p] = bus_wdata[(p % PINS_PER_FWORD)*FSEL_W +: FSEL_W];
                if (kind == RG_SET && int'(idx) == p / WORD_W && bus_wdata[p % WORD_W])
                    state_d.dout[p] = 1'b1;
                if (kind == RG_CLR && int'(idx) == p / WORD_W && bus_wdata[p % WORD_W])
                    state_d.dout[p] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    // read mux: set/clear and unmapped locations return zero
    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            if (kind == RG_FSEL && int'(idx) == p / PINS_PER_FWORD)
                bus_rdata[(p % PINS_PER_FWORD)*FSEL_W +: FSEL_W] = state_q.fsel[p];
            if (kind == RG_LEV && int'(idx) == p / WORD_W)
                bus_rdata[p % WORD_W] = lev[p];
        end
    end

    assign pad_out = state_q.dout;
endmodule

// File: rtl/gpio_core_chk.sv
module gpio_core_chk #(
    parameter int NUM_PINS = 54,
    parameter int ADDR_W   = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_we,
    input logic [ADDR_W-1:0]     bus_addr,
    input logic                  wbit0,
    input logic [31:0]           bus_rdata,
    input logic                  lvl0,
    input logic                  out0,
    input logic [NUM_PINS-1:0]   pad_oe,
    input logic [NUM_PINS*3-1:0] pad_alt_sel
);
    logic [1:0] warm_q;
    always_ff @(posedge clk) begin
        if (!rst_n)              warm_q <= '0;
        else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
    end

    // R1
    reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_alt_sel == '0 && !out0));

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_ex
        // R3
        oe_alt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pad_oe[p] |-> pad_alt_sel[p*3 +: 3] == 3'd0);
    end

    // R5
    set_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h1C) && wbit0) |=> out0);

    // R5
    set_zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h1C) && !wbit0) |=> $stable(out0));

    // R6
    clr_pin0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'('h28) && wbit0) |=> !out0);

    // R7
    setclr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h1C) || bus_addr == ADDR_W'('h28)) |-> bus_rdata == '0);

    // R8
    level_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'('h34) && warm_q == 2'd3) |-> bus_rdata[0] == $past(lvl0, 2));
endmodule

bind pinmux_gpio_core gpio_core_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .wbit0      (bus_wdata[0]),
    .bus_rdata  (bus_rdata),
    .lvl0       (pad_in[0]),
    .out0       (pad_out[0]),
    .pad_oe     (pad_oe),
    .pad_alt_sel(pad_alt_sel)
);

// File: tb/pinmux_gpio_core_bench.sv
`timescale 1ns/1ps
module pinmux_gpio_core_bench;
    localparam int NP = 54;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_we = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NP-1:0]  pad_in = '0;
    logic [NP-1:0]  pad_out;
    logic [NP-1:0]  pad_oe;
    logic [NP*3-1:0] pad_alt_sel;

    always #2.5 clk = ~clk;

    pinmux_gpio_core u_pinmux_gpio_core (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_alt_sel(pad_alt_sel)
    );

    int n_chk = 0;
    int n_fail = 0;

    logic [2:0]    m_fsel [NP];
    logic [NP-1:0] m_out;
    logic [NP-1:0] m_lev;

    task automatic chk(input string req, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = '0;
        int w = int'(a) / 4;
        if (w < 6) begin
            for (int j = 0; j < 10; j++)
                if (w*10 + j < NP) r[j*3 +: 3] = m_fsel[w*10 + j];
        end else if (w == 13 || w == 14) begin
            for (int k = 0; k < 32; k++)
                if ((w-13)*32 + k < NP) r[k] = m_lev[(w-13)*32 + k];
        end
        return r;
    endfunction

    function automatic logic [191:0] exp_oe();
        logic [191:0] v = '0;
        for (int p = 0; p < NP; p++) v[p] = (m_fsel[p] == 3'd1);
        return v;
    endfunction

    function automatic logic [191:0] exp_alt();
        logic [191:0] v = '0;
        for (int p = 0; p < NP; p++) v[p*3 +: 3] = (m_fsel[p] < 3'd2) ? 3'd0 : m_fsel[p];
        return v;
    endfunction

    // bench model of one register write
    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        int w = int'(a) / 4;
        if (w < 6) begin
            for (int j = 0; j < 10; j++)
                if (w*10 + j < NP) m_fsel[w*10 + j] = d[j*3 +: 3];
        end else if (w == 7 || w == 8 || w == 10 || w == 11) begin
            for (int k = 0; k < 32; k++) begin
                int p = ((w == 7 || w == 10) ? 0 : 32) + k;
                if (p < NP && d[k]) m_out[p] = (w < 10);
            end
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        model_wr(a, d);
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a);
        bus_addr = a;
        #1;
        chk(req, {160'd0, bus_rdata}, {160'd0, exp_rd(a)});
    endtask

    task automatic pads_chk();
        chk("R3 pad_oe", {138'd0, pad_oe}, exp_oe());
        chk("R4 pad_alt_sel", {30'd0, pad_alt_sel}, exp_alt());
        chk("R5/R6 pad_out", {138'd0, pad_out}, {138'd0, m_out});
    endtask

    // watchdog
    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int p = 0; p < NP; p++) m_fsel[p] = 3'd0;
        m_out = '0;
        m_lev = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", {138'd0, pad_oe}, 192'd0);
        chk("R1 alt", {30'd0, pad_alt_sel}, 192'd0);
        chk("R1 out", {138'd0, pad_out}, 192'd0);
        for (int w = 0; w < 6; w++) rd_chk("R1 fsel word", 8'(w*4));

        // R2 unused top bits of a function word
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R2 word0 readback", 8'h00);
        chk("R2 top bits zero", {160'd0, bus_rdata & 32'hC000_0000}, 192'd0);
        pads_chk();

        // R9 last function word holds only pins 50..53
        wr(8'h14, 32'hFFFF_FFFF);
        bus_addr = 8'h14; #1;
        chk("R9 word5 partial", {160'd0, bus_rdata}, {160'd0, 32'h0000_0FFF});

        // R3/R4 every code on pins 10..17
        wr(8'h04, {8'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd1, 3'd0});
        chk("R3 only pin11 enabled", {181'd0, pad_oe[17:10]}, 192'h02);
        chk("R4 alt fields pins10-17", {168'd0, pad_alt_sel[53:30]},
            {168'd0, 3'd7, 3'd6, 3'd5, 3'd4, 3'd3, 3'd2, 3'd0, 3'd0});
        pads_chk();

        // R5/R7/R9 set bank 1 incl. unimplemented bits
        wr(8'h20, 32'hFFFF_FFFF);
        chk("R5 bank1 set", {170'd0, pad_out[53:32]}, {170'd0, 22'h3F_FFFF});
        rd_chk("R7 set reads zero", 8'h20);
        rd_chk("R7 clear reads zero", 8'h2C);
        // R6 zero data leaves latches alone
        wr(8'h2C, 32'h0);
        chk("R6 zero clear ignored", {170'd0, pad_out[53:32]}, {170'd0, 22'h3F_FFFF});
        wr(8'h2C, 32'h0000_0005);
        chk("R6 clear bits 32,34", {170'd0, pad_out[53:32]}, {170'd0, 22'h3F_FFFA});
        // R9 unmapped offsets
        wr(8'h18, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
        rd_chk("R9 unmapped 0x18", 8'h18);
        rd_chk("R9 unmapped 0x3C", 8'h3C);
        pads_chk();

        // R10 latch written in input mode
        wr(8'h00, 32'h0);
        wr(8'h1C, 32'h0000_0020);
        chk("R10 out while input", {190'd0, pad_out[5], pad_oe[5]}, 192'd2);

        // R8 synchronizer latency
        @(negedge clk);
        pad_in = {NP{1'b1}};
        @(negedge clk);
        bus_addr = 8'h34; #1;
        chk("R8 not after one edge", {160'd0, bus_rdata}, 192'd0);
        @(negedge clk);
        m_lev = pad_in;
        rd_chk("R8 visible after two edges", 8'h34);
        rd_chk("R9 bank1 level upper zero", 8'h38);

        // random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom % 4;
            if (op == 0) begin
                wr(8'(($urandom % 7) * 4), $urandom);
            end else if (op == 1) begin
                wr(($urandom % 2) ? 8'h20 : 8'h1C, $urandom & $urandom & $urandom);
            end else if (op == 2) begin
                wr(($urandom % 2) ? 8'h2C : 8'h28, $urandom & $urandom & $urandom);
            end else begin
                @(negedge clk);
                pad_in = NP'({$urandom, $urandom});
                repeat (2) @(negedge clk);
                m_lev = pad_in;
            end
            pads_chk();
            rd_chk("R2/R8 random read", 8'(($urandom % 20) * 4));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule